// File: doc/BRIEF.md
# Divide-by-Three Sequencer

This block divides its clock by three. A two-bit state register walks through the values 0, 1, 2 and then returns to 0. A one-cycle pulse marks each pass through state 2, so the pulse rate is one third of the clock rate.

The state register is built three times in parallel, each from a different kind of storage primitive:

- two D-type bits;
- a toggle bit for the high position and a set/clear/toggle (JK) bit for the low position;
- two JK bits.

Every version carries its own excitation logic. A comparator raises a flag when the three versions disagree. All three state vectors are brought out to ports so that a bench can follow the sequence of each one.

The fourth encoding (binary 11) is not part of the count. In every version it is a trap: it maps to itself, and no legal state ever leads to it. Only the synchronous reset takes the block out of the trap.

Top module: `div3_top`

## Requirements
- R1: While `rst` is high at a rising clock edge, every state output becomes 0 at that edge. After that edge `pulseOut` and `mismatch` read 0.
- R2: After `rst` falls, the k-th following rising edge leaves each state output equal to k mod 3. The count advances one step per clock: 0 to 1, 1 to 2, 2 to 0.
- R3: `pulseOut` is 1 exactly when the state is 2 (binary 10), and 0 in states 0, 1 and 3. Each pulse lasts one cycle, and consecutive pulses start three clocks apart.
- R4: State 3 (binary 11) leads only to itself in each of the three versions, with `pulseOut` held at 0.
- R5: In the all-D version, the high bit loads the current low bit. The low bit loads the XNOR of the two current bits.
- R6: In the mixed version, the high bit toggles when the two current bits differ. The low bit is a JK cell with both J and K equal to the inverse of the current high bit.
- R7: In the all-JK version, the high bit has J equal to the low bit and K equal to the inverted low bit. The low bit has J and K both equal to the inverted high bit.
- R8: `mismatch` is 1 whenever the three state vectors are not all equal. It stays 0 in every cycle after reset while they agree.
- R9: Reset applied from any state, including state 3, returns all versions to 0 at the first rising edge with `rst` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock to be divided |
| rst | input | 1 | Synchronous reset, active high |
| pulseOut | output | 1 | One-cycle pulse, taken from the all-D version in state 2 |
| stateD | output | 2 | State of the all-D version |
| stateMixed | output | 2 | State of the toggle plus JK version |
| stateJk | output | 2 | State of the all-JK version |
| mismatch | output | 1 | The three versions disagree |

## Verification
The assertions assume that `rst` is high at the first clock edge. They also assume that the state only reaches binary 11 while `rst` is high. Once `rst` falls, that state can only be entered together with reset, so the transition and agreement properties are disabled around the entry.

The bench follows both assumptions. It overrides all six storage bits to 1 at the same moment, with reset held, and it lets them go as reset falls. All three versions therefore enter the trap in the same cycle, and every property stays valid outside the reset window.

// File: rtl/div3_pkg.sv
package div3_pkg;
  localparam int STATE_W = 2;
  localparam int NUM_VER = 3;
  typedef logic [STATE_W-1:0] state_t;

  localparam state_t ST_ZERO = 2'd0;
  localparam state_t ST_ONE  = 2'd1;
  localparam state_t ST_TWO  = 2'd2;
  localparam state_t ST_TRAP = 2'd3;

  // Excitation strobes from the control to the storage bits.
  typedef struct packed {
    logic dHi;
    logic dLo;
    logic tHi;
    logic jMixLo;
    logic kMixLo;
    logic jJkHi;
    logic kJkHi;
    logic jJkLo;
    logic kJkLo;
  } excite_t;
endpackage

// File: rtl/div3_cells.sv
module div3_dcell (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= d;
  end
endmodule

module div3_tcell (
  input  logic clk,
  input  logic rst,
  input  logic t,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= q ^ t;
  end

  // R6: a toggle request flips the bit at the next edge
  p_toggle_r6: assert property (@(posedge clk) disable iff (rst)
    t |=> q != $past(q));
endmodule

module div3_jkcell (
  input  logic clk,
  input  logic rst,
  input  logic j,
  input  logic k,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= (j & ~q) | (~k & q);
  end

  // R7: J without K sets the bit, K without J clears it
  p_jk_set_r7: assert property (@(posedge clk) disable iff (rst)
    (j && !k) |=> q);
  p_jk_clr_r7: assert property (@(posedge clk) disable iff (rst)
    (k && !j) |=> !q);
endmodule

// File: rtl/div3_ctrl.sv
module div3_ctrl
  import div3_pkg::*;
(
  input  state_t  qD,
  input  state_t  qMixed,
  input  state_t  qJk,
  output excite_t exc
);
  always_comb begin
    // All-D version
    exc.dHi    = qD[0];
    exc.dLo    = ~(qD[1] ^ qD[0]);
    // Toggle high bit, JK low bit
    exc.tHi    = qMixed[1] ^ qMixed[0];
    exc.jMixLo = ~qMixed[1];
    exc.kMixLo = ~qMixed[1];
    // All-JK version
    exc.jJkHi  = qJk[0];
    exc.kJkHi  = ~qJk[0];
    exc.jJkLo  = ~qJk[1];
    exc.kJkLo  = ~qJk[1];
  end
endmodule

// File: rtl/div3_dpath.sv
module div3_dpath
  import div3_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  excite_t exc,
  output state_t  qD,
  output state_t  qMixed,
  output state_t  qJk
);
  div3_dcell  dHi  (.clk(clk), .rst(rst), .d(exc.dHi), .q(qD[1]));
  div3_dcell  dLo  (.clk(clk), .rst(rst), .d(exc.dLo), .q(qD[0]));
  div3_tcell  tHi  (.clk(clk), .rst(rst), .t(exc.tHi), .q(qMixed[1]));
  div3_jkcell jkLo (.clk(clk), .rst(rst), .j(exc.jMixLo), .k(exc.kMixLo), .q(qMixed[0]));
  div3_jkcell jHi  (.clk(clk), .rst(rst), .j(exc.jJkHi), .k(exc.kJkHi), .q(qJk[1]));
  div3_jkcell jLo  (.clk(clk), .rst(rst), .j(exc.jJkLo), .k(exc.kJkLo), .q(qJk[0]));

  state_t verState [NUM_VER];
  assign verState[0] = qD;
  assign verState[1] = qMixed;
  assign verState[2] = qJk;

  for (genvar v = 0; v < NUM_VER; v++) begin : g_seqCheck
    p_step0_r2: assert property (@(posedge clk) disable iff (rst)
      verState[v] == ST_ZERO |=> verState[v] == ST_ONE);
    p_step1_r2: assert property (@(posedge clk) disable iff (rst)
      verState[v] == ST_ONE |=> verState[v] == ST_TWO);
    p_step2_r2: assert property (@(posedge clk) disable iff (rst)
      verState[v] == ST_TWO |=> verState[v] == ST_ZERO);
    p_trap_r4: assert property (@(posedge clk) disable iff (rst)
      verState[v] == ST_TRAP |=> verState[v] == ST_TRAP);
  end
endmodule

// File: rtl/div3_top.sv
module div3_top
  import div3_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  output logic       pulseOut,
  output logic [1:0] stateD,
  output logic [1:0] stateMixed,
  output logic [1:0] stateJk,
  output logic       mismatch
);
  excite_t exc;
  state_t  qD, qMixed, qJk;
  logic    pulseD, pulseMixed, pulseJk;

  div3_ctrl ctrl (.qD(qD), .qMixed(qMixed), .qJk(qJk), .exc(exc));
  div3_dpath dpath (.clk(clk), .rst(rst), .exc(exc),
                    .qD(qD), .qMixed(qMixed), .qJk(qJk));

  assign pulseD     = qD[1] & ~qD[0];
  assign pulseMixed = qMixed[1] & ~qMixed[0];
  assign pulseJk    = qJk[1] & ~qJk[0];

  assign pulseOut   = pulseD;
  assign stateD     = qD;
  assign stateMixed = qMixed;
  assign stateJk    = qJk;
  assign mismatch   = (qD != qMixed) || (qD != qJk) ||
                      (pulseD != pulseMixed) || (pulseD != pulseJk);

  // R3: a pulse lasts one cycle and is followed by state 0
  p_pulse_single_r3: assert property (@(posedge clk) disable iff (rst)
    pulseOut |=> !pulseOut);
  p_pulse_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    pulseOut |=> stateD == ST_ZERO);
  // R8: the versions never disagree once out of reset
  p_agree_r8: assert property (@(posedge clk) disable iff (rst)
    !mismatch);
  // R1: one edge with reset high yields state 0
  p_reset_r1: assert property (@(posedge clk)
    $fell(rst) |-> stateD == ST_ZERO || stateD == ST_TRAP);
endmodule

// File: tb/div3_top_test.sv
module div3_top_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pulseOut, mismatch;
  logic [1:0] stateD, stateMixed, stateJk;
  int checks = 0;
  int errors = 0;
  int lastPulse = -1;
  bit done = 1'b0;

  always #5 clk = ~clk;

  div3_top uut (.clk(clk), .rst(rst), .pulseOut(pulseOut), .stateD(stateD),
                .stateMixed(stateMixed), .stateJk(stateJk), .mismatch(mismatch));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chkAll(input int exp, input string tag);
    chk(stateD == 2'(exp),     {tag, " R5 stateD"},     stateD, exp);
    chk(stateMixed == 2'(exp), {tag, " R6 stateMixed"}, stateMixed, exp);
    chk(stateJk == 2'(exp),    {tag, " R7 stateJk"},    stateJk, exp);
    chk(pulseOut == (exp == 2), {tag, " R3 pulse"}, pulseOut, int'(exp == 2));
    chk(!mismatch, {tag, " R8 mismatch"}, mismatch, 0);
  endtask

  task automatic runCount(input int n, input int startCycle);
    for (int k = 1; k <= n; k++) begin
      @(posedge clk); @(negedge clk);
      chkAll((startCycle + k) % 3, "R2 count");
      if (pulseOut) begin
        if (lastPulse >= 0)
          chk(k - lastPulse == 3, "R3 period", k - lastPulse, 3);
        lastPulse = k;
      end
    end
  endtask

  initial begin
    #1000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(posedge clk); @(posedge clk); @(negedge clk);
    chkAll(0, "R1 reset");
    rst = 1'b0;
    lastPulse = -1;
    runCount(30, 0);

    // R9: reset entered from each legal phase
    for (int p = 0; p < 3; p++) begin
      @(negedge clk) rst = 1'b1;
      @(posedge clk); @(negedge clk);
      chkAll(0, "R9 reset from phase");
      rst = 1'b0;
      lastPulse = -1;
      runCount(p, 0);
      chk(stateD == 2'(p), "R2 phase reached", stateD, p);
    end

    // R4: place all versions in state 3 together, under reset
    @(negedge clk);
    rst = 1'b1;
    force uut.dpath.dHi.q  = 1'b1;
    force uut.dpath.dLo.q  = 1'b1;
    force uut.dpath.tHi.q  = 1'b1;
    force uut.dpath.jkLo.q = 1'b1;
    force uut.dpath.jHi.q  = 1'b1;
    force uut.dpath.jLo.q  = 1'b1;
    @(posedge clk); @(negedge clk);
    release uut.dpath.dHi.q;
    release uut.dpath.dLo.q;
    release uut.dpath.tHi.q;
    release uut.dpath.jkLo.q;
    release uut.dpath.jHi.q;
    release uut.dpath.jLo.q;
    rst = 1'b0;
    for (int k = 0; k < 6; k++) begin
      @(posedge clk); @(negedge clk);
      chkAll(3, "R4 trap hold");
    end

    // R9: reset leaves the trap
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    chkAll(0, "R9 reset from trap");
    rst = 1'b0;
    lastPulse = -1;
    runCount(9, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule